// File: doc/BRIEF.md
# Dual-Channel Converter Output Formatter

This block sits after a pair of 10-bit sample converters and decides what appears on the two 10-bit output buses. A power-control byte holds two 4-bit power settings. The level of a shutdown pin selects which of the two is in force. The live setting gives each channel a power state, and it can also turn on an averaging mode that sends the mean of the two channels out on a single bus. A 4-bit format field selects one of three layouts: two independent buses, or one bus that carries both channels in turn at twice the sample rate. Either bus can also be presented with its bits in reverse order.

Sample pairs enter on a valid/ready stream. A pair is taken when `s_valid` and `s_ready` are both high. The power and format configuration in force at that edge is captured with the pair. Each captured pair produces one output slot, or two slots in interleaved mode. A slot stays on the output until `m_ready` is seen high at a clock edge, and `m_ready` low holds it unchanged. `s_ready` is high when no pair is held, or when the last slot of the held pair completes at this edge. This lets full-rate streaming continue without a bubble. The per-channel power-state outputs are decoded directly from the live pins.

Top module: `adc_out_fmt`

## Requirements
- R1: The power setting in force is `pwr_cfg[7:4]` when `shdn_in` is 1 and `pwr_cfg[3:0]` when it is 0. Each nibble is laid out as {avg, stby, b_on, a_on}, from bit 3 down to bit 0.
- R2: When avg is 0, a channel with its on bit set is ACTIVE (2). A channel with its on bit clear is STANDBY (1) if stby is 1 and OFF (0) otherwise. These states appear on `pstate_a` and `pstate_b`.
- R3: When avg is 1 and at least one on bit is set, both channels are ACTIVE and the formatter is in averaging mode. The output value is (A+B)>>1, which is the 11-bit sum with its LSB dropped. When avg is 1 and both on bits are clear, both channels are STANDBY if stby is 1 and OFF otherwise.
- R4: In averaging mode, each pair produces one slot. The average goes to bus B if `fmt_cfg[1]` is 1 and to bus A otherwise. The other bus drives zero and its valid is low.
- R5: When not averaging and `fmt_cfg[0]` is 0, each pair produces one slot. Bus A carries channel A and bus B carries channel B.
- R6: When not averaging and `fmt_cfg[0]` is 1, each pair produces two slots on the bus selected by `fmt_cfg[1]`. With 0, the data goes to bus A, channel A first and then channel B. With 1, it goes to bus B, channel B first and then channel A. `slot_chan` is 1 while channel B occupies the slot. The other bus drives zero with its valid low.
- R7: `fmt_cfg[2]` reverses the bit order of bus A and `fmt_cfg[3]` reverses bus B. The reversal is the final stage, so it also applies to averaged and interleaved data.
- R8: A slot carrying a channel that is not ACTIVE drives zero on its bus, with that bus's valid low.
- R9: A slot is held unchanged while `m_ready` is low. `s_ready` is low while a held slot has not completed and during the first of two interleaved slots. `s_valid` has no effect while `s_ready` is low.
- R10: After reset, both buses are zero, both valids are low, `slot_chan` is 0 and `s_ready` is 1.
- R11: The power and format configuration is sampled when a pair is accepted. Later changes to `shdn_in`, `pwr_cfg` or `fmt_cfg` do not alter that pair's slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shdn_in | input | 1 | Selects which power nibble is live |
| pwr_cfg | input | 8 | Two power nibbles: [7:4] for shutdown high, [3:0] for shutdown low |
| fmt_cfg | input | 4 | [0] interleave, [1] bus select, [2] reverse bus A, [3] reverse bus B |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Sample pair accepted at this edge if valid |
| smp_a | input | 10 | Channel A sample |
| smp_b | input | 10 | Channel B sample |
| m_ready | input | 1 | Downstream takes the current slot |
| bus_a | output | 10 | Output bus A |
| bus_b | output | 10 | Output bus B |
| bus_a_vld | output | 1 | Bus A carries data |
| bus_b_vld | output | 1 | Bus B carries data |
| slot_chan | output | 1 | Interleaved slot owner: 0 channel A, 1 channel B |
| pstate_a | output | 2 | Channel A power state: 0 OFF, 1 STANDBY, 2 ACTIVE |
| pstate_b | output | 2 | Channel B power state, same encoding |

## Verification
The hardest case to reach is a configuration change that lands while a captured pair is still on the output. This happens during a stalled first slot of an interleaved pair, when the design must ignore both the new pins and a new `s_valid`. The stimulus sweeps every live nibble, every shutdown level and every format value over a set of corner sample pairs. On every seventh pair it drops `m_ready`, then raises `s_valid` with different data and inverts all configuration pins during the stall. It then checks that the held slot and all later slots still follow the configuration captured at acceptance.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  typedef enum logic [1:0] {
    PWR_OFF  = 2'd0,
    PWR_STBY = 2'd1,
    PWR_ON   = 2'd2
  } pwr_state_e;

  typedef struct packed {
    logic en_a;
    logic en_b;
    logic avg;
    logic mux;
    logic sel;
    logic rev_a;
    logic rev_b;
  } mode_t;
endpackage

// File: rtl/adc_pwr_decode.sv
module adc_pwr_decode
  import adc_fmt_pkg::*;
(
  input  logic       shdn_in,
  input  logic [7:0] pwr_cfg,
  output pwr_state_e state_a,
  output pwr_state_e state_b,
  output logic       avg
);
  logic [3:0] nib;
  logic       hps, stby, b_on, a_on;
  pwr_state_e idle_st;

  // R1: live nibble follows the shutdown pin
  assign nib  = shdn_in ? pwr_cfg[7:4] : pwr_cfg[3:0];
  assign hps  = nib[3];
  assign stby = nib[2];
  assign b_on = nib[1];
  assign a_on = nib[0];

  assign idle_st = stby ? PWR_STBY : PWR_OFF;
  assign avg     = hps & (a_on | b_on);

  always_comb begin
    if (hps) begin
      state_a = avg ? PWR_ON : idle_st;   // R3
      state_b = avg ? PWR_ON : idle_st;
    end else begin
      state_a = a_on ? PWR_ON : idle_st;  // R2
      state_b = b_on ? PWR_ON : idle_st;
    end
  end
endmodule

// File: rtl/adc_slot_ctrl.sv
module adc_slot_ctrl
  import adc_fmt_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  mode_t         in_mode,
  input  logic          m_ready,
  output logic          full,
  output logic          phase,
  output logic [DW-1:0] hold_a,
  output logic [DW-1:0] hold_b,
  output mode_t         hold_mode
);
  logic two_slot, last_slot, take, done_slot;

  assign two_slot  = hold_mode.mux & ~hold_mode.avg;
  assign last_slot = ~two_slot | phase;
  assign done_slot = full & m_ready;
  // R9: accept only when empty or when the final slot leaves now
  assign s_ready   = ~full | (last_slot & m_ready);
  assign take      = s_valid & s_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full      <= 1'b0;
      phase     <= 1'b0;
      hold_a    <= '0;
      hold_b    <= '0;
      hold_mode <= '0;
    end else if (take) begin
      full      <= 1'b1;
      phase     <= 1'b0;
      hold_a    <= in_a;
      hold_b    <= in_b;
      hold_mode <= in_mode;    // R11: capture config with the pair
    end else if (done_slot) begin
      if (last_slot) begin
        full  <= 1'b0;
        phase <= 1'b0;
      end else begin
        phase <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_bus_map.sv
module adc_bus_map
  import adc_fmt_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          full,
  input  logic          phase,
  input  logic [DW-1:0] hold_a,
  input  logic [DW-1:0] hold_b,
  input  mode_t         mode,
  output logic [DW-1:0] bus_a,
  output logic [DW-1:0] bus_b,
  output logic          vld_a,
  output logic          vld_b,
  output logic          chan
);
  logic [DW:0]   sum;
  logic [DW-1:0] mean, pick, raw_a, raw_b, flip_a, flip_b;
  logic          pick_en;

  assign sum  = {1'b0, hold_a} + {1'b0, hold_b};
  assign mean = sum[DW:1];                       // R3: drop LSB

  assign chan    = full & mode.mux & ~mode.avg & (mode.sel ^ phase);
  assign pick    = chan ? hold_b : hold_a;
  assign pick_en = chan ? mode.en_b : mode.en_a;

  always_comb begin
    raw_a = '0;
    raw_b = '0;
    vld_a = 1'b0;
    vld_b = 1'b0;
    if (full) begin
      if (mode.avg) begin                        // R4
        if (mode.sel) begin
          raw_b = mean;
          vld_b = 1'b1;
        end else begin
          raw_a = mean;
          vld_a = 1'b1;
        end
      end else if (mode.mux) begin               // R6
        if (mode.sel) begin
          raw_b = pick_en ? pick : '0;
          vld_b = pick_en;
        end else begin
          raw_a = pick_en ? pick : '0;
          vld_a = pick_en;
        end
      end else begin                             // R5, R8
        raw_a = mode.en_a ? hold_a : '0;
        vld_a = mode.en_a;
        raw_b = mode.en_b ? hold_b : '0;
        vld_b = mode.en_b;
      end
    end
  end

  // R7: bit reversal as the last stage
  for (genvar i = 0; i < DW; i++) begin : g_rev
    assign flip_a[i] = raw_a[DW-1-i];
    assign flip_b[i] = raw_b[DW-1-i];
  end

  assign bus_a = mode.rev_a ? flip_a : raw_a;
  assign bus_b = mode.rev_b ? flip_b : raw_b;
endmodule

// File: rtl/adc_out_fmt.sv
module adc_out_fmt
  import adc_fmt_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shdn_in,
  input  logic [7:0]    pwr_cfg,
  input  logic [3:0]    fmt_cfg,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] smp_a,
  input  logic [DW-1:0] smp_b,
  input  logic          m_ready,
  output logic [DW-1:0] bus_a,
  output logic [DW-1:0] bus_b,
  output logic          bus_a_vld,
  output logic          bus_b_vld,
  output logic          slot_chan,
  output logic [1:0]    pstate_a,
  output logic [1:0]    pstate_b
);
  pwr_state_e    st_a, st_b;
  logic          avg_live, full, phase;
  mode_t         live_mode, hold_mode;
  logic [DW-1:0] hold_a, hold_b;

  adc_pwr_decode u_pwr (
    .shdn_in (shdn_in),
    .pwr_cfg (pwr_cfg),
    .state_a (st_a),
    .state_b (st_b),
    .avg     (avg_live)
  );

  assign pstate_a = st_a;
  assign pstate_b = st_b;

  always_comb begin
    live_mode.en_a  = (st_a == PWR_ON);
    live_mode.en_b  = (st_b == PWR_ON);
    live_mode.avg   = avg_live;
    live_mode.mux   = fmt_cfg[0];
    live_mode.sel   = fmt_cfg[1];
    live_mode.rev_a = fmt_cfg[2];
    live_mode.rev_b = fmt_cfg[3];
  end

  adc_slot_ctrl #(.DW(DW)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .in_a      (smp_a),
    .in_b      (smp_b),
    .in_mode   (live_mode),
    .m_ready   (m_ready),
    .full      (full),
    .phase     (phase),
    .hold_a    (hold_a),
    .hold_b    (hold_b),
    .hold_mode (hold_mode)
  );

  adc_bus_map #(.DW(DW)) u_map (
    .full   (full),
    .phase  (phase),
    .hold_a (hold_a),
    .hold_b (hold_b),
    .mode   (hold_mode),
    .bus_a  (bus_a),
    .bus_b  (bus_b),
    .vld_a  (bus_a_vld),
    .vld_b  (bus_b_vld),
    .chan   (slot_chan)
  );
endmodule

// File: rtl/adc_out_fmt_chk.sv
module adc_out_fmt_chk #(
  parameter int DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_ready,
  input logic          m_ready,
  input logic [DW-1:0] bus_a,
  input logic [DW-1:0] bus_b,
  input logic          bus_a_vld,
  input logic          bus_b_vld,
  input logic          slot_chan
);
  p_quiet_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_a_vld |-> bus_a == '0);

  p_quiet_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_b_vld |-> bus_b == '0);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_a_vld || bus_b_vld) && !m_ready) |=>
      ($stable(bus_a) && $stable(bus_b) && $stable(bus_a_vld)
       && $stable(bus_b_vld) && $stable(slot_chan)));

  p_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_a_vld || bus_b_vld) && !m_ready) |-> !s_ready);

  p_chan_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slot_chan) |-> $past(m_ready));
endmodule

bind adc_out_fmt adc_out_fmt_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_ready   (s_ready),
  .m_ready   (m_ready),
  .bus_a     (bus_a),
  .bus_b     (bus_b),
  .bus_a_vld (bus_a_vld),
  .bus_b_vld (bus_b_vld),
  .slot_chan (slot_chan)
);

// File: tb/sim_adc_out_fmt.sv
module sim_adc_out_fmt;
  localparam int DW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          shdn_in = 1'b0;
  logic [7:0]    pwr_cfg = '0;
  logic [3:0]    fmt_cfg = '0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [DW-1:0] smp_a = '0;
  logic [DW-1:0] smp_b = '0;
  logic          m_ready = 1'b0;
  logic [DW-1:0] bus_a, bus_b;
  logic          bus_a_vld, bus_b_vld, slot_chan;
  logic [1:0]    pstate_a, pstate_b;

  int n_chk = 0;
  int n_bad = 0;
  int n_txn = 0;

  always #10 clk = ~clk;

  adc_out_fmt #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .shdn_in(shdn_in), .pwr_cfg(pwr_cfg),
    .fmt_cfg(fmt_cfg), .s_valid(s_valid), .s_ready(s_ready),
    .smp_a(smp_a), .smp_b(smp_b), .m_ready(m_ready),
    .bus_a(bus_a), .bus_b(bus_b), .bus_a_vld(bus_a_vld),
    .bus_b_vld(bus_b_vld), .slot_chan(slot_chan),
    .pstate_a(pstate_a), .pstate_b(pstate_b)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] flip(input logic [DW-1:0] x);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = x[DW-1-i];
    return r;
  endfunction

  function automatic logic [22:0] observe();
    return {bus_a, bus_b, bus_a_vld, bus_b_vld, slot_chan};
  endfunction

  task automatic run_txn(input logic [DW-1:0] a, input logic [DW-1:0] b,
                         input logic sh, input logic [7:0] pw,
                         input logic [3:0] fm, input bit stall);
    logic [3:0]    nib;
    logic          hps, stby, bon, aon, avg, ena, enb;
    logic [1:0]    sa, sb, idle;
    logic [DW-1:0] mean, da, db;
    logic [22:0]   exp_slot [2];
    int            nslots;
    string         tag;
    nib  = sh ? pw[7:4] : pw[3:0];
    hps  = nib[3]; stby = nib[2]; bon = nib[1]; aon = nib[0];
    avg  = hps && (aon || bon);
    idle = stby ? 2'd1 : 2'd0;
    sa   = hps ? (avg ? 2'd2 : idle) : (aon ? 2'd2 : idle);
    sb   = hps ? (avg ? 2'd2 : idle) : (bon ? 2'd2 : idle);
    ena  = (sa == 2'd2);
    enb  = (sb == 2'd2);
    mean = DW'((int'(a) + int'(b)) / 2);

    if (avg) begin
      nslots = 1; tag = "R3/R4/R7";
      da = fm[1] ? '0 : mean;
      db = fm[1] ? mean : '0;
      exp_slot[0] = {fm[2] ? flip(da) : da, fm[3] ? flip(db) : db,
                     !fm[1], fm[1], 1'b0};
      exp_slot[1] = '0;
    end else if (fm[0]) begin
      nslots = 2; tag = "R6/R7/R8";
      for (int s = 0; s < 2; s++) begin
        logic          isb, en;
        logic [DW-1:0] v;
        isb = fm[1] ^ (s == 1);
        en  = isb ? enb : ena;
        v   = en ? (isb ? b : a) : '0;
        da  = fm[1] ? '0 : v;
        db  = fm[1] ? v : '0;
        exp_slot[s] = {fm[2] ? flip(da) : da, fm[3] ? flip(db) : db,
                       !fm[1] && en, fm[1] && en, isb};
      end
    end else begin
      nslots = 1; tag = "R5/R7/R8";
      da = ena ? a : '0;
      db = enb ? b : '0;
      exp_slot[0] = {fm[2] ? flip(da) : da, fm[3] ? flip(db) : db,
                     ena, enb, 1'b0};
      exp_slot[1] = '0;
    end

    @(negedge clk);
    smp_a = a; smp_b = b; shdn_in = sh; pwr_cfg = pw; fmt_cfg = fm;
    s_valid = 1'b1; m_ready = 1'b1;
    #1;
    chk(s_ready == 1'b1, "R9 ready when empty", 32'(s_ready), 32'd1);
    chk({pstate_a, pstate_b} == {sa, sb}, "R1/R2/R3 power states",
        32'({pstate_a, pstate_b}), 32'({sa, sb}));
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0; smp_a = ~a; smp_b = ~b;

    for (int s = 0; s < nslots; s++) begin
      if (stall && s == 0) begin
        // R9/R11: stall with new data offered and config pins inverted
        m_ready = 1'b0; s_valid = 1'b1;
        shdn_in = ~sh; pwr_cfg = ~pw; fmt_cfg = ~fm;
        #1;
        chk(s_ready == 1'b0, "R9 blocked under stall", 32'(s_ready), 32'd0);
        @(posedge clk);
        @(negedge clk);
        s_valid = 1'b0;
        chk(observe() == exp_slot[0], "R11 held slot ignores new pins",
            32'(observe()), 32'(exp_slot[0]));
        m_ready = 1'b1;
      end
      #1;
      chk(observe() == exp_slot[s], tag, 32'(observe()), 32'(exp_slot[s]));
      if (nslots == 2 && s == 0)
        chk(s_ready == 1'b0, "R9 first interleaved slot blocks input",
            32'(s_ready), 32'd0);
      @(posedge clk);
      @(negedge clk);
    end
    shdn_in = sh; pwr_cfg = pw; fmt_cfg = fm;
    #1;
    chk(observe() == '0, "R8 idle after pair drained", 32'(observe()), 32'd0);
    n_txn++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] pa [4];
    logic [DW-1:0] pb [4];
    pa[0] = 10'h3FF; pb[0] = 10'h3FF;
    pa[1] = 10'h001; pb[1] = 10'h002;
    pa[2] = 10'h155; pb[2] = 10'h2AA;
    pa[3] = 10'h3FF; pb[3] = 10'h000;

    repeat (3) @(negedge clk);
    #1;
    chk(observe() == '0, "R10 outputs after reset", 32'(observe()), 32'd0);
    chk(s_ready == 1'b1, "R10 ready after reset", 32'(s_ready), 32'd1);
    rst_n = 1'b1;

    for (int sh = 0; sh < 2; sh++)
      for (int nb = 0; nb < 16; nb++)
        for (int fm = 0; fm < 16; fm++)
          for (int k = 0; k < 4; k++) begin
            logic [7:0] pw;
            // other nibble is the complement, so the wrong pick shows (R1)
            pw = sh[0] ? {4'(nb), ~4'(nb)} : {~4'(nb), 4'(nb)};
            run_txn(pa[k], pb[k], sh[0], pw, 4'(fm), (n_txn % 7) == 3);
          end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule